// File: doc/BRIEF.md
# Remote Frame Auto-Response Sequencer

This controller sits inside a CAN message-buffer engine and runs once a received frame has been validated on the sixth end-of-frame bit. The validated frame waits in a hidden staging buffer. When a receive buffer matches, the controller spends a fixed copy phase moving the frame into that buffer. When the frame is a remote request, it then walks the message buffers in ascending index order. Each buffer whose 4-bit status holds the "reply pending" code is retagged to the "reply once" code. Finally it spends a fixed scheduling phase and raises a transmit request for the lowest-indexed buffer that was retagged. That buffer answers with a data frame that carries the same identifier and a cleared RTR bit.

Every phase has a fixed cycle cost: 17 cycles for the copy, 3 per retagged buffer, and 2 for the schedule. The whole sequence therefore has a known length and must fit inside the four bit times between validation and the earliest next transmission start, which follows the third intermission bit. With 15 buffers the longest run is 17 + 15*3 + 2 = 64 cycles. The usual worst case is 14 retags, which gives 61 cycles.

The controller has four states:
- IDLE waits for the frame-valid strobe.
- COPY counts the copy phase.
- UPD counts one retag.
- SCHED counts the scheduling phase.

It has seven transitions:
- IDLE to COPY when a strobe arrives with a matching receive buffer.
- IDLE to UPD when a strobe arrives without a match, the frame is a remote request, and at least one buffer is pending.
- COPY to UPD at the end of the copy when pending buffers were captured.
- COPY to IDLE at the end of the copy otherwise.
- UPD to UPD after a retag while pending buffers remain.
- UPD to SCHED after the last retag.
- SCHED to IDLE at the end of the schedule.

Top module: `rfr_seq`

## Requirements
- R1: After reset, busy, overrun, copy_we, st_we and tx_req are all low.
- R2: A frame_ok strobe with match_hit=1, accepted in idle, raises copy_we for one cycle exactly 17 clock edges after the strobe is sampled. copy_idx equals the match_idx given with the strobe.
- R3: For a remote frame (frame_rtr=1), every buffer whose status field buf_status[4*i+3:4*i] equals the pending code (default 4'hA) gets exactly one st_we pulse. The pulse carries st_idx=i and st_code equal to the reply-once code (default 4'hB). Pulses come in ascending index order, 3 cycles apart; the first comes 3 cycles after the copy ends, or 3 edges after the strobe when there is no copy.
- R4: Buffers whose status holds any code other than the pending code never get an st_we pulse.
- R5: After the last retag, tx_req pulses exactly 2 cycles later with tx_idx equal to the lowest retagged buffer index.
- R6: busy is high from the first cycle after an accepted strobe through the cycle of the final strobe of the sequence, then low. At most one of copy_we, st_we and tx_req is high in any cycle, and only while busy.
- R7: A frame_ok strobe sampled while busy raises overrun in the next cycle. The strobe is otherwise ignored and adds no write or transmit pulse.
- R8: A remote frame with no pending buffer produces no st_we and no tx_req.
- R9: A sequence lasts 17*copy + 3*retags + 2*schedule cycles, at most 64 cycles with the default 15 buffers.
- R10: A strobe with match_hit=0 and frame_rtr=0 causes no activity, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_ok | input | 1 | One-cycle strobe: received frame validated |
| frame_rtr | input | 1 | Validated frame is a remote request |
| match_hit | input | 1 | A receive buffer matched the frame |
| match_idx | input | 4 | Index of the matching receive buffer |
| buf_status | input | 60 | 15 status fields of 4 bits, buffer i at bits 4*i+3:4*i |
| busy | output | 1 | Sequence in progress |
| overrun | output | 1 | Strobe arrived while busy (one-cycle pulse) |
| copy_we | output | 1 | Write strobe for the hidden-buffer copy |
| copy_idx | output | 4 | Receive buffer written by the copy |
| st_we | output | 1 | Status write strobe for a retag |
| st_idx | output | 4 | Buffer being retagged |
| st_code | output | 4 | New status code written |
| tx_req | output | 1 | Transmit request pulse |
| tx_idx | output | 4 | Buffer scheduled for transmission |

## Verification
A corrupted state or phase counter shows up as a write or transmit pulse in the wrong cycle. A bad mask shows up as a pulse for the wrong buffer, a pulse that is missing, or a pulse that appears twice. The scoreboard pins every pulse to its exact cycle and index, so the error is reported on the cycle it first reaches the ports. A stuck busy or a skipped schedule shows within one sequence: the busy length is compared with the 17/3/2 cost formula, and the checker bounds each run at 64 cycles.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_COPY,
        S_UPD,
        S_SCHED
    } rfr_state_e;
endpackage

// File: rtl/rfr_step_timer.sv
// Phase counter: loaded with (cost - 1), counts down, flags the last cycle.
module rfr_step_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/rfr_code_match.sv
// Flags every buffer whose status field holds CODE.
module rfr_code_match #(
    parameter int          NUM_BUF = 15,
    parameter int          SW      = 4,
    parameter logic [SW-1:0] CODE  = '0
) (
    input  logic [NUM_BUF*SW-1:0] status,
    output logic [NUM_BUF-1:0]    hit
);
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
        assign hit[g] = (status[g*SW +: SW] == CODE);
    end
endmodule

// File: rtl/rfr_pend_finder.sv
// Lowest-index priority encoder.
module rfr_pend_finder #(
    parameter int NUM_BUF = 15,
    parameter int IW      = 4
) (
    input  logic [NUM_BUF-1:0] mask,
    output logic               any,
    output logic [IW-1:0]      idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (mask[i])
                idx = IW'(i);
        end
        any = |mask;
    end
endmodule

// File: rtl/rfr_seq.sv
module rfr_seq
    import rfr_pkg::*;
#(
    parameter int            NUM_BUF   = 15,
    parameter int            SW        = 4,
    parameter int            COPY_CYC  = 17,
    parameter int            UPD_CYC   = 3,
    parameter int            SCHED_CYC = 2,
    parameter logic [SW-1:0] PEND_CODE = 4'hA,
    parameter logic [SW-1:0] ONCE_CODE = 4'hB,
    localparam int           IW        = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ok,
    input  logic                  frame_rtr,
    input  logic                  match_hit,
    input  logic [IW-1:0]         match_idx,
    input  logic [NUM_BUF*SW-1:0] buf_status,
    output logic                  busy,
    output logic                  overrun,
    output logic                  copy_we,
    output logic [IW-1:0]         copy_idx,
    output logic                  st_we,
    output logic [IW-1:0]         st_idx,
    output logic [SW-1:0]         st_code,
    output logic                  tx_req,
    output logic [IW-1:0]         tx_idx
);
    localparam int MAXC = (COPY_CYC > UPD_CYC) ?
                          ((COPY_CYC > SCHED_CYC) ? COPY_CYC : SCHED_CYC) :
                          ((UPD_CYC > SCHED_CYC) ? UPD_CYC : SCHED_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    rfr_state_e          state_q, state_d;
    logic [NUM_BUF-1:0]  live_mask, mask_q, sel_mask, rest_mask;
    logic                sel_any, rest_any, last;
    logic [IW-1:0]       cur_idx, copy_idx_q, tx_idx_q;
    logic                tx_set_q, overrun_q;
    logic                tm_load;
    logic [CW-1:0]       tm_val;

    rfr_code_match #(.NUM_BUF(NUM_BUF), .SW(SW), .CODE(PEND_CODE)) u_match (
        .status (buf_status),
        .hit    (live_mask)
    );

    assign sel_mask = (state_q == S_IDLE) ? live_mask : mask_q;

    rfr_pend_finder #(.NUM_BUF(NUM_BUF), .IW(IW)) u_find (
        .mask (sel_mask),
        .any  (sel_any),
        .idx  (cur_idx)
    );

    assign rest_mask = mask_q & ~(NUM_BUF'(1) << cur_idx);
    assign rest_any  = |rest_mask;

    rfr_step_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .last     (last)
    );

    // Next state and phase-counter loading
    always_comb begin
        state_d = state_q;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (frame_ok && match_hit) begin
                    state_d = S_COPY;
                    tm_load = 1'b1;
                    tm_val  = CW'(COPY_CYC - 1);
                end else if (frame_ok && frame_rtr && sel_any) begin
                    state_d = S_UPD;
                    tm_load = 1'b1;
                    tm_val  = CW'(UPD_CYC - 1);
                end
            end
            S_COPY: begin
                if (last) begin
                    if (sel_any) begin
                        state_d = S_UPD;
                        tm_load = 1'b1;
                        tm_val  = CW'(UPD_CYC - 1);
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_UPD: begin
                if (last) begin
                    tm_load = 1'b1;
                    if (rest_any) begin
                        tm_val = CW'(UPD_CYC - 1);
                    end else begin
                        state_d = S_SCHED;
                        tm_val  = CW'(SCHED_CYC - 1);
                    end
                end
            end
            S_SCHED: begin
                if (last)
                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            mask_q     <= '0;
            copy_idx_q <= '0;
            tx_idx_q   <= '0;
            tx_set_q   <= 1'b0;
            overrun_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            overrun_q <= frame_ok && (state_q != S_IDLE);
            if (state_q == S_IDLE && frame_ok) begin
                mask_q     <= frame_rtr ? live_mask : '0;
                copy_idx_q <= match_idx;
                tx_set_q   <= 1'b0;
            end
            if (state_q == S_UPD && last) begin
                mask_q <= rest_mask;
                if (!tx_set_q) begin
                    tx_set_q <= 1'b1;
                    tx_idx_q <= cur_idx;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        overrun  = overrun_q;
        copy_we  = (state_q == S_COPY) && last;
        copy_idx = copy_idx_q;
        st_we    = (state_q == S_UPD) && last;
        st_idx   = cur_idx;
        st_code  = ONCE_CODE;
        tx_req   = (state_q == S_SCHED) && last;
        tx_idx   = tx_idx_q;
    end
endmodule

// File: rtl/rfr_seq_chk.sv
module rfr_seq_chk #(
    parameter int            NUM_BUF   = 15,
    parameter int            SW        = 4,
    parameter int            COPY_CYC  = 17,
    parameter int            UPD_CYC   = 3,
    parameter int            SCHED_CYC = 2,
    parameter logic [SW-1:0] PEND_CODE = 4'hA,
    parameter int            IW        = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_ok,
    input logic [NUM_BUF*SW-1:0] buf_status,
    input logic                  busy,
    input logic                  overrun,
    input logic                  copy_we,
    input logic                  st_we,
    input logic [IW-1:0]         st_idx,
    input logic                  tx_req
);
    localparam int BUDGET = COPY_CYC + NUM_BUF * UPD_CYC + SCHED_CYC;

    int unsigned   run_cnt;
    logic          have_prev;
    logic [IW-1:0] prev_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt   <= 0;
            have_prev <= 1'b0;
            prev_idx  <= '0;
        end else begin
            run_cnt <= busy ? run_cnt + 1 : 0;
            if (!busy)
                have_prev <= 1'b0;
            else if (st_we) begin
                have_prev <= 1'b1;
                prev_idx  <= st_idx;
            end
        end
    end

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({copy_we, st_we, tx_req}));
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_we || st_we || tx_req) |-> busy);
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && busy) |=> overrun);
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !overrun);
    p_pend_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (buf_status[st_idx*SW +: SW] == PEND_CODE));
    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && have_prev) |-> (st_idx > prev_idx));
    p_tx_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !busy);
    p_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < BUDGET));
endmodule

bind rfr_seq rfr_seq_chk #(
    .NUM_BUF   (NUM_BUF),
    .SW        (SW),
    .COPY_CYC  (COPY_CYC),
    .UPD_CYC   (UPD_CYC),
    .SCHED_CYC (SCHED_CYC),
    .PEND_CODE (PEND_CODE),
    .IW        (IW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_ok   (frame_ok),
    .buf_status (buf_status),
    .busy       (busy),
    .overrun    (overrun),
    .copy_we    (copy_we),
    .st_we      (st_we),
    .st_idx     (st_idx),
    .tx_req     (tx_req)
);

// File: tb/rfr_seq_bench.sv
`timescale 1ns/1ps
module rfr_seq_bench;
    localparam int NB   = 15;
    localparam int SW   = 4;
    localparam logic [3:0] PEND = 4'hA;
    localparam logic [3:0] ONCE = 4'hB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_ok = 1'b0, frame_rtr = 1'b0, match_hit = 1'b0;
    logic [3:0]    match_idx = '0;
    logic [NB*SW-1:0] buf_status = '0;
    logic          busy, overrun, copy_we, st_we, tx_req;
    logic [3:0]    copy_idx, st_idx, st_code, tx_idx;

    always #2.5 clk = ~clk;

    rfr_seq u_rfr_seq (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_rtr(frame_rtr),
        .match_hit(match_hit), .match_idx(match_idx), .buf_status(buf_status),
        .busy(busy), .overrun(overrun), .copy_we(copy_we), .copy_idx(copy_idx),
        .st_we(st_we), .st_idx(st_idx), .st_code(st_code),
        .tx_req(tx_req), .tx_idx(tx_idx)
    );

    typedef struct { int kind; int idx; int cyc; } ev_t;
    ev_t exp_q[$];
    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic string kind_req(int k);
        return (k == 0) ? "R2" : (k == 1) ? "R3" : "R5";
    endfunction

    // Monitor: compare each produced pulse with the scoreboard head
    task automatic observe(int kind, int idx);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, (kind == 1) ? "R4 unexpected st_we" : "R8 unexpected pulse",
                  idx, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind && e.idx == idx && e.cyc == cyc, kind_req(e.kind),
                  kind * 10000 + idx * 100 + cyc, e.kind * 10000 + e.idx * 100 + e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (copy_we) observe(0, int'(copy_idx));
            if (st_we) begin
                observe(1, int'(st_idx));
                check(st_code == ONCE, "R3 st_code", int'(st_code), int'(ONCE));
            end
            if (tx_req) observe(2, int'(tx_idx));
        end
    end

    // Driver: one frame, expected pulses pushed, busy length checked (R6, R9)
    task automatic send(bit hit, int midx, bit rtr, logic [NB*SW-1:0] st, int ovr_at);
        int t = 0, first = -1, t0, nbusy = 0;
        @(negedge clk);
        buf_status = st; frame_ok = 1'b1; match_hit = hit;
        match_idx = 4'(midx); frame_rtr = rtr;
        t0 = cyc;
        if (hit) begin t += 17; exp_q.push_back('{0, midx, t0 + t}); end
        if (rtr) begin
            for (int i = 0; i < NB; i++) begin
                if (st[i*SW +: SW] == PEND) begin
                    t += 3;
                    exp_q.push_back('{1, i, t0 + t});
                    if (first < 0) first = i;
                end
            end
            if (first >= 0) begin t += 2; exp_q.push_back('{2, first, t0 + t}); end
        end
        @(negedge clk);
        frame_ok = 1'b0;
        for (int k = 1; k <= t + 3; k++) begin
            if (busy) nbusy++;
            if (k == t + 1) check(!busy, "R6 busy drop", int'(busy), 0);
            if (ovr_at != 0 && k == ovr_at + 1) begin
                frame_ok = 1'b0;
                check(overrun, "R7 overrun", int'(overrun), 1);
            end
            if (ovr_at != 0 && k == ovr_at) begin
                frame_ok = 1'b1; match_hit = 1'b1; match_idx = 4'd9; frame_rtr = 1'b1;
            end
            @(negedge clk);
        end
        check(nbusy == t, (t == 0) ? "R10 busy length" : "R9 busy length", nbusy, t);
    endtask

    function automatic logic [NB*SW-1:0] mk(int pend_bits, logic [3:0] other);
        logic [NB*SW-1:0] s;
        for (int i = 0; i < NB; i++)
            s[i*SW +: SW] = pend_bits[i] ? PEND : other;
        return s;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !overrun && !copy_we && !st_we && !tx_req, "R1 reset",
              {busy, overrun, copy_we, st_we, tx_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !overrun, "R1 after release", {busy, overrun}, 0);

        send(1'b1, 5, 1'b0, mk(15'h7FFF, 4'h0), 0);          // R2 data frame only
        send(1'b1, 2, 1'b1, mk(15'h0212, ONCE), 0);          // R3 R4 R5 copy+3 retags
        send(1'b0, 0, 1'b1, mk(15'h4000, 4'h3), 0);          // R3 R5 no copy, top index
        send(1'b1, 0, 1'b1, mk(15'h0000, ONCE), 0);          // R8 no pending buffer
        send(1'b0, 0, 1'b1, mk(15'h0000, 4'h0), 0);          // R8 R10 nothing at all
        send(1'b0, 7, 1'b0, mk(15'h0F0F, 4'h0), 0);          // R10 no match, not remote
        send(1'b1, 3, 1'b0, mk(15'h0000, 4'h0), 5);          // R7 strobe during copy
        send(1'b1, 14, 1'b1, mk(15'h7FFF, 4'h0), 0);         // R9 worst case 64 cycles
        send(1'b1, 1, 1'b1, mk(15'h5555, 4'h7), 0);          // R3 R4 alternating

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 R5 missing pulses", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule